// File: doc/BRIEF.md
# Speculative Single-Bit Synchronizer with Fail-and-Retry

This block moves a one-bit "data available" flag from a sending clock domain into a receiving clock domain. It does not wait a full synchronization period before reporting. On each falling edge of the read clock it takes two samples of the incoming flag: an early one and a slightly later speculative one. The speculative sample is shown at once on `spec_valid`, in the middle of the read cycle.

On the following rising edge the two samples move into a second pair of flops. A small receive controller then judges them. When they agree, the speculative decision was sound. When they disagree, the decision may have been wrong, and `fail` is raised for one read cycle. A raised `fail` keeps the read-done acknowledge low, so the receiver's read pointer does not move and the flag is simply taken again on the next falling edge. Each failure therefore costs one read cycle.

Metastability itself is not modelled. A test hook lets a bench supply the two first-stage samples directly, so that the disagreeing cases can be produced on demand.

Top module: `specsync_top`

## Requirements
- R1: While `rst_n` is low, `spec_valid`, `fail` and `read_done` are 0, and every sample flop is cleared.
- R2: Each falling edge of `clk_rd` takes an early and a speculative sample. `spec_valid` shows the speculative sample from that falling edge until the next one.
- R3: Early 0 with speculative 0 yields `fail`=0 and `read_done`=0 in the read cycle that starts at the next rising edge.
- R4: Early 1 with speculative 1 yields `read_done`=1 and `fail`=0 in the read cycle that starts at the next rising edge.
- R5: Early 0 with speculative 1 yields `fail`=1 and `read_done`=0 in the read cycle that starts at the next rising edge.
- R6: Early 1 with speculative 0 is treated as a failure (`fail`=1, `read_done`=0). It can arise only through the test hook, never from `avail_in`.
- R7: The verdict for a sample taken at a falling edge appears at the next rising edge, half a cycle after `spec_valid`, and holds for exactly one read cycle. `fail` and `read_done` are never high together.
- R8: After a failure the flag is sampled again at the very next falling edge. With `avail_in` held at 1, `read_done` follows exactly one read cycle after the failing verdict.
- R9: With `hook_en`=0, both samples take the value of `avail_in`. With `hook_en`=1, the early sample takes `hook_early` and the speculative sample takes `hook_spec`, whatever `avail_in` is.
- R10: A new speculative sample on `spec_valid` and the verdict on the previous sample are presented together in the second half of a read cycle, and neither disturbs the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rd | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| avail_in | input | 1 | Data-available flag from the sending domain |
| hook_en | input | 1 | Test hook: 1 selects the hook values for both first-stage samples |
| hook_early | input | 1 | Test hook value for the early sample |
| hook_spec | input | 1 | Test hook value for the speculative sample |
| spec_valid | output | 1 | Speculative data available, updated at each falling edge |
| fail | output | 1 | The previous speculative decision is untrustworthy |
| read_done | output | 1 | Confirmed read acknowledge, held low whenever `fail` is high |

## Verification
In the second half of every read cycle, the new speculative sample on `spec_valid` is present at the same time as the verdict on the sample taken one cycle earlier. The bench provokes this in two ways. It forces a disagreeing sample pair through the hook and follows it directly with a real high flag. It also places two forced failures back to back. The scoreboard judges the verdict one cycle after each sample. The driver checks, at mid-cycle, that `spec_valid` already carries the new sample while `fail` and `read_done` still carry the earlier verdict.

// File: rtl/specsync_pkg.sv
package specsync_pkg;

  // Verdict over one early/speculative sample pair.
  typedef enum logic [1:0] {
    VERD_IDLE    = 2'd0,  // both low: no data, correct
    VERD_DATA    = 2'd1,  // both high: data, correct
    VERD_SUSPECT = 2'd2,  // early low, speculative high: retry
    VERD_ILLEGAL = 2'd3   // early high, speculative low: cannot happen naturally
  } verdict_t;

  function automatic verdict_t judge(input logic early_s, input logic spec_s);
    verdict_t v;
    case ({early_s, spec_s})
      2'b00:   v = VERD_IDLE;
      2'b11:   v = VERD_DATA;
      2'b01:   v = VERD_SUSPECT;
      default: v = VERD_ILLEGAL;
    endcase
    return v;
  endfunction

  function automatic logic is_failure(input verdict_t v);
    return (v == VERD_SUSPECT) || (v == VERD_ILLEGAL);
  endfunction

  function automatic logic is_confirmed(input verdict_t v);
    return v == VERD_DATA;
  endfunction

endpackage

// File: rtl/specsync_sampler.sv
// First stage: early and speculative samples on the falling read edge.
module specsync_sampler (
  input  logic clk_rd,
  input  logic rst_n,
  input  logic avail_in,
  input  logic hook_en,
  input  logic hook_early,
  input  logic hook_spec,
  output logic early_l,
  output logic spec_l,
  output logic hook_l
);
  logic early_d;
  logic spec_d;

  always_comb begin
    early_d = hook_en ? hook_early : avail_in;
    spec_d  = hook_en ? hook_spec  : avail_in;
  end

  always_ff @(negedge clk_rd or negedge rst_n) begin
    if (!rst_n) begin
      early_l <= 1'b0;
      spec_l  <= 1'b0;
      hook_l  <= 1'b0;
    end else begin
      early_l <= early_d;
      spec_l  <= spec_d;
      hook_l  <= hook_en;
    end
  end
endmodule

// File: rtl/specsync_resolver.sv
// Second stage: both samples registered on the rising read edge.
module specsync_resolver (
  input  logic clk_rd,
  input  logic rst_n,
  input  logic early_l,
  input  logic spec_l,
  input  logic hook_l,
  output logic early_q,
  output logic spec_q,
  output logic hook_q
);
  always_ff @(posedge clk_rd or negedge rst_n) begin
    if (!rst_n) begin
      early_q <= 1'b0;
      spec_q  <= 1'b0;
      hook_q  <= 1'b0;
    end else begin
      early_q <= early_l;
      spec_q  <= spec_l;
      hook_q  <= hook_l;
    end
  end
endmodule

// File: rtl/specsync_rxctl.sv
// Receive controller: judges the resolved pair and gates the acknowledge.
module specsync_rxctl
  import specsync_pkg::*;
(
  input  logic early_q,
  input  logic spec_q,
  output logic fail,
  output logic read_done
);
  verdict_t verdict;

  always_comb begin
    verdict   = judge(early_q, spec_q);
    fail      = is_failure(verdict);
    read_done = is_confirmed(verdict) & ~fail;
  end
endmodule

// File: rtl/specsync_top.sv
module specsync_top (
  input  logic clk_rd,
  input  logic rst_n,
  input  logic avail_in,
  input  logic hook_en,
  input  logic hook_early,
  input  logic hook_spec,
  output logic spec_valid,
  output logic fail,
  output logic read_done
);
  logic early_l;
  logic spec_l;
  logic hook_l;
  logic early_q;
  logic spec_q;
  logic hook_q;

  specsync_sampler u_sampler (
    .clk_rd     (clk_rd),
    .rst_n      (rst_n),
    .avail_in   (avail_in),
    .hook_en    (hook_en),
    .hook_early (hook_early),
    .hook_spec  (hook_spec),
    .early_l    (early_l),
    .spec_l     (spec_l),
    .hook_l     (hook_l)
  );

  specsync_resolver u_resolver (
    .clk_rd  (clk_rd),
    .rst_n   (rst_n),
    .early_l (early_l),
    .spec_l  (spec_l),
    .hook_l  (hook_l),
    .early_q (early_q),
    .spec_q  (spec_q),
    .hook_q  (hook_q)
  );

  specsync_rxctl u_rxctl (
    .early_q   (early_q),
    .spec_q    (spec_q),
    .fail      (fail),
    .read_done (read_done)
  );

  assign spec_valid = spec_l;
endmodule

// File: rtl/specsync_chk.sv
module specsync_chk (
  input logic clk_rd,
  input logic rst_n,
  input logic spec_valid,
  input logic fail,
  input logic read_done,
  input logic early_q,
  input logic spec_q,
  input logic hook_q
);
  // R1: outputs are quiet while reset is held
  assert_reset_quiet_R1: assert property (@(posedge clk_rd)
    !rst_n |-> (!spec_valid && !fail && !read_done));

  // R4/R5: a high speculative sample always ends in a verdict one edge later
  assert_spec_judged_R4: assert property (@(posedge clk_rd) disable iff (!rst_n)
    spec_valid |=> (read_done || fail));

  // R3: a low speculative sample never turns into an acknowledge
  assert_no_false_done_R3: assert property (@(posedge clk_rd) disable iff (!rst_n)
    !spec_valid |=> !read_done);

  // R6: early-high with speculative-low only ever comes through the hook
  assert_illegal_only_hook_R6: assert property (@(posedge clk_rd) disable iff (!rst_n)
    (early_q && !spec_q) |-> hook_q);

  // R7: a failing verdict blocks the acknowledge
  assert_fail_blocks_done_R7: assert property (@(posedge clk_rd) disable iff (!rst_n)
    fail |-> !read_done);
endmodule

bind specsync_top specsync_chk u_chk (
  .clk_rd     (clk_rd),
  .rst_n      (rst_n),
  .spec_valid (spec_valid),
  .fail       (fail),
  .read_done  (read_done),
  .early_q    (early_q),
  .spec_q     (spec_q),
  .hook_q     (hook_q)
);

// File: tb/specsync_top_test.sv
module specsync_top_test;
  logic clk_rd = 1'b0;
  logic rst_n = 1'b0;
  logic avail_in = 1'b0;
  logic hook_en = 1'b0;
  logic hook_early = 1'b0;
  logic hook_spec = 1'b0;
  logic spec_valid;
  logic fail;
  logic read_done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit prev_fail = 1'b0;
  bit prev_done = 1'b0;
  bit done_flag = 1'b0;

  typedef struct {
    int    due;
    bit    exp_fail;
    bit    exp_done;
    string tag;
  } exp_t;
  exp_t sb[$];

  specsync_top uut (
    .clk_rd     (clk_rd),
    .rst_n      (rst_n),
    .avail_in   (avail_in),
    .hook_en    (hook_en),
    .hook_early (hook_early),
    .hook_spec  (hook_spec),
    .spec_valid (spec_valid),
    .fail       (fail),
    .read_done  (read_done)
  );

  always #4 clk_rd = ~clk_rd;  // 125 MHz

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Driver: applies one sample per read cycle and queues its verdict.
  task automatic drive(input bit a, input bit he, input bit e, input bit s, input string tag);
    bit ee;
    bit ss;
    exp_t it;
    @(posedge clk_rd);
    #1;
    avail_in = a; hook_en = he; hook_early = e; hook_spec = s;
    ee = he ? e : a;
    ss = he ? s : a;
    it.due = cyc + 1;
    it.exp_fail = (ee != ss);
    it.exp_done = ee & ss;
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk_rd);
    #1;
    // R2/R9: new speculative sample visible at mid-cycle
    chk({tag, " R2 spec_valid"}, spec_valid, ss);
    // R10/R7: verdict of the previous sample still shown alongside
    chk({tag, " R10 fail"}, fail, prev_fail);
    chk({tag, " R10 read_done"}, read_done, prev_done);
    prev_fail = it.exp_fail;
    prev_done = it.exp_done;
  endtask

  // Monitor: compares verdicts as they appear.
  initial begin
    forever begin
      @(posedge clk_rd);
      cyc++;
      #2;
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t it;
        it = sb.pop_front();
        chk({it.tag, " R7 fail"}, fail, it.exp_fail);
        chk({it.tag, " R7 read_done"}, read_done, it.exp_done);
      end
    end
  end

  initial begin
    #40000;
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    avail_in = 1'b1;  // must not leak through while reset is held
    repeat (3) @(posedge clk_rd);
    #1;
    chk("R1 spec_valid in reset", spec_valid, 0);
    chk("R1 fail in reset", fail, 0);
    chk("R1 read_done in reset", read_done, 0);
    avail_in = 1'b0;
    @(negedge clk_rd);
    #1;
    rst_n = 1'b1;

    drive(0, 0, 0, 0, "R3 idle");
    drive(0, 0, 0, 0, "R3 idle");
    drive(1, 0, 0, 0, "R4 R9 flag high");
    drive(1, 0, 0, 0, "R4 flag high again");
    drive(0, 0, 0, 0, "R3 flag low");
    drive(1, 1, 0, 1, "R5 forced suspect");
    drive(1, 0, 0, 0, "R8 retry after suspect");
    drive(1, 1, 0, 1, "R5 suspect one");
    drive(1, 1, 0, 1, "R5 suspect two");
    drive(1, 0, 0, 0, "R8 retry after two");
    drive(0, 1, 1, 0, "R6 forced illegal");
    drive(0, 0, 0, 0, "R3 after illegal");
    drive(0, 1, 1, 1, "R9 hook overrides low flag");
    drive(1, 1, 0, 0, "R9 hook overrides high flag");
    drive(1, 0, 0, 0, "R4 alternate");
    drive(0, 0, 0, 0, "R3 alternate");
    drive(1, 0, 0, 0, "R4 alternate");
    drive(0, 0, 0, 0, "R3 drain");
    drive(0, 0, 0, 0, "R3 drain");
    repeat (2) @(posedge clk_rd);
    #3;
    chk("R7 scoreboard drained", sb.size(), 0);
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule